// File: doc/BRIEF.md
# GPIO Pin Interrupt Detector

This block watches the eight pins of a general-purpose I/O port and turns their activity into one interrupt line. Each pin picks its own trigger: a level that matches a programmed polarity, a single edge (rising or falling), or any change. Detected events land in a sticky raw status register. Software clears that register one bit at a time by writing ones. A mask chooses which status bits can reach the interrupt output.

The pin values come in already synchronized. A direction vector marks which pins are driven by the port itself, and those pins never produce edge events. Software reaches the configuration through a simple register bus. A write takes effect on the clock edge at which it is presented. Read data is combinational from the address. The bus always accepts and has no back-pressure, and the interrupt is a plain level output. The pin data path and pad control belong to other blocks.

Top module: `gpio_irq_top`

## Requirements
- R1: After reset the trigger-type, any-change, polarity, mask and raw status registers read 0, the interrupt output is low, and the stored previous pin sample is 0.
- R2: Software reads and writes its configuration at these byte offsets, with one bit per pin: trigger type 0x404 (1 = level, 0 = edge), any-change 0x408, polarity 0x40C, mask 0x410.
- R3: An edge pin with its any-change bit set to 1 sets its raw status bit on any change of level. The bit is readable after the clock edge that first samples the new level.
- R4: An edge pin with its any-change bit set to 0 sets its raw status bit only on a transition to its polarity level. Polarity 1 selects rising edges and polarity 0 selects falling edges.
- R5: A level pin sets its raw status bit on every clock in which the pin equals its polarity bit, whatever its direction bit.
- R6: Edge events come only from pins whose direction bit is 0 (input). A pin with direction bit 1 never sets its bit in edge mode.
- R7: Raw status bits (read at 0x414) are sticky. A write to 0x41C clears each bit written as 1 and leaves the bits written as 0. A level pin that is still active keeps its bit set.
- R8: When a clear and a new event hit the same bit in the same clock, the bit stays set.
- R9: The masked status read at 0x418 equals raw status AND mask. The interrupt output is high exactly when any masked bit is 1.
- R10: Writes to 0x414 and 0x418 have no effect. Reads of 0x41C and of unmapped offsets return 0.
- R11: Edge detection compares each pin with its sample from the previous clock, so a pin held steady produces no further events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | 8 | Synchronized pin levels |
| dir_i | input | 8 | Pin direction, 1 = output |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Register byte offset |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| irq_o | output | 1 | Combined interrupt |

## Verification
The hardest case to reach is a clear write and a fresh event on the same bit in the same clock. The bench changes the pin on the same falling edge that presents the clear, so the detector and the clear meet at one rising edge. A table walk covers the trigger types by letting the pins settle at a start value, clearing the status, and then applying one step to a second value. The table includes mixed-mode rows, and a level-low source that is still active during the clear.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_SENSE  = 12'h404;
  localparam logic [ADDR_W-1:0] OFS_ANY    = 12'h408;
  localparam logic [ADDR_W-1:0] OFS_POL    = 12'h40C;
  localparam logic [ADDR_W-1:0] OFS_MASK   = 12'h410;
  localparam logic [ADDR_W-1:0] OFS_RAW    = 12'h414;
  localparam logic [ADDR_W-1:0] OFS_MASKED = 12'h418;
  localparam logic [ADDR_W-1:0] OFS_CLEAR  = 12'h41C;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_SENSE, SEL_ANY, SEL_POL, SEL_MASK, SEL_RAW, SEL_MASKED, SEL_CLEAR
  } reg_sel_e;

  function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
    case (a)
      OFS_SENSE:  return SEL_SENSE;
      OFS_ANY:    return SEL_ANY;
      OFS_POL:    return SEL_POL;
      OFS_MASK:   return SEL_MASK;
      OFS_RAW:    return SEL_RAW;
      OFS_MASKED: return SEL_MASKED;
      OFS_CLEAR:  return SEL_CLEAR;
      default:    return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  input  logic [NPINS-1:0]  raw_i,
  input  logic [NPINS-1:0]  masked_i,
  output logic [NPINS-1:0]  sense_o,
  output logic [NPINS-1:0]  any_o,
  output logic [NPINS-1:0]  pol_o,
  output logic [NPINS-1:0]  mask_o,
  output logic [NPINS-1:0]  clr_o,
  output logic [NPINS-1:0]  rdata_o
);
  reg_sel_e sel;
  assign sel = decode_addr(addr_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_o <= '0;
      any_o   <= '0;
      pol_o   <= '0;
      mask_o  <= '0;
    end else if (wr_i) begin
      case (sel)
        SEL_SENSE: sense_o <= wdata_i;
        SEL_ANY:   any_o   <= wdata_i;
        SEL_POL:   pol_o   <= wdata_i;
        SEL_MASK:  mask_o  <= wdata_i;
        default:   ;
      endcase
    end
  end

  assign clr_o = (wr_i && sel == SEL_CLEAR) ? wdata_i : '0;

  always_comb begin
    case (sel)
      SEL_SENSE:  rdata_o = sense_o;
      SEL_ANY:    rdata_o = any_o;
      SEL_POL:    rdata_o = pol_o;
      SEL_MASK:   rdata_o = mask_o;
      SEL_RAW:    rdata_o = raw_i;
      SEL_MASKED: rdata_o = masked_i;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin_i,
  input  logic [NPINS-1:0] dir_i,
  input  logic [NPINS-1:0] sense_i,
  input  logic [NPINS-1:0] any_i,
  input  logic [NPINS-1:0] pol_i,
  output logic [NPINS-1:0] event_o
);
  logic [NPINS-1:0] pin_q;

  always_ff @(posedge clk) begin
    if (rst) pin_q <= '0;
    else     pin_q <= pin_i;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic changed;
    logic at_pol;
    assign changed = (pin_i[g] ^ pin_q[g]) & ~dir_i[g];
    assign at_pol  = ~(pin_i[g] ^ pol_i[g]);
    always_comb begin
      if (sense_i[g]) event_o[g] = at_pol;
      else            event_o[g] = changed & (any_i[g] | at_pol);
    end
  end
endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int NPINS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] event_i,
  input  logic [NPINS-1:0] clr_i,
  input  logic [NPINS-1:0] mask_i,
  output logic [NPINS-1:0] raw_o,
  output logic [NPINS-1:0] masked_o,
  output logic             irq_o
);
  always_ff @(posedge clk) begin
    if (rst) raw_o <= '0;
    else     raw_o <= (raw_o & ~clr_i) | event_i;
  end

  assign masked_o = raw_o & mask_i;
  assign irq_o    = |masked_o;
endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int NPINS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPINS-1:0]  pin_i,
  input  logic [NPINS-1:0]  dir_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [NPINS-1:0]  bus_wdata_i,
  output logic [NPINS-1:0]  bus_rdata_o,
  output logic              irq_o
);
  logic [NPINS-1:0] sense_q, any_q, pol_q, mask_q, clr_w;
  logic [NPINS-1:0] event_w, raw_q, masked_w;

  gpio_irq_regs #(.NPINS(NPINS)) u_regs (
    .clk(clk), .rst(rst), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .raw_i(raw_q), .masked_i(masked_w),
    .sense_o(sense_q), .any_o(any_q), .pol_o(pol_q), .mask_o(mask_q),
    .clr_o(clr_w), .rdata_o(bus_rdata_o)
  );

  gpio_irq_detect #(.NPINS(NPINS)) u_detect (
    .clk(clk), .rst(rst), .pin_i(pin_i), .dir_i(dir_i),
    .sense_i(sense_q), .any_i(any_q), .pol_i(pol_q), .event_o(event_w)
  );

  gpio_irq_status #(.NPINS(NPINS)) u_status (
    .clk(clk), .rst(rst), .event_i(event_w), .clr_i(clr_w), .mask_i(mask_q),
    .raw_o(raw_q), .masked_o(masked_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk #(
  parameter int NPINS = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [NPINS-1:0] pin_i,
  input logic [NPINS-1:0] dir_i,
  input logic [NPINS-1:0] sense_q,
  input logic [NPINS-1:0] pol_q,
  input logic [NPINS-1:0] clr_w,
  input logic [NPINS-1:0] event_w,
  input logic [NPINS-1:0] raw_q,
  input logic             irq_o
);
  logic [NPINS-1:0] keep_w;
  assign keep_w = raw_q & ~clr_w;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (raw_q == '0 && !irq_o));

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & $past(keep_w)) == $past(keep_w)));

  // R8
  event_wins_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((~raw_q & $past(event_w)) == '0));

  // R6
  output_pin_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((raw_q & ~$past(raw_q) & $past(~sense_q & dir_i)) == '0));

  // R5
  level_sets_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(sense_q & ~(pin_i ^ pol_q)) & ~raw_q) == '0));
endmodule

bind gpio_irq_top gpio_irq_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rst(rst), .pin_i(pin_i), .dir_i(dir_i), .sense_q(sense_q),
  .pol_q(pol_q), .clr_w(clr_w), .event_w(event_w), .raw_q(raw_q), .irq_o(irq_o)
);

// File: tb/gpio_irq_top_test.sv
module gpio_irq_top_test;
  localparam logic [11:0] A_SENSE = 12'h404, A_ANY = 12'h408, A_POL = 12'h40C,
                          A_MASK = 12'h410, A_RAW = 12'h414, A_MSKD = 12'h418,
                          A_CLR = 12'h41C;

  logic clk = 0, rst = 1;
  logic [7:0] pin = 0, dir = 0, wdata = 0;
  logic wr = 0;
  logic [11:0] addr = 0;
  logic [7:0] rdata;
  logic irq;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  gpio_irq_top uut (
    .clk(clk), .rst(rst), .pin_i(pin), .dir_i(dir), .bus_wr_i(wr),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq)
  );

  typedef struct packed {
    logic [7:0] sense, any, pol, dir, mask, pa, pb, raw;
    logic       irq;
  } vec_t;

  // sense, any, pol, dir, mask, start pins, step pins, expected raw, expected irq
  localparam vec_t VEC [0:6] = '{
    '{8'h00, 8'hFF, 8'h00, 8'h00, 8'hFF, 8'h00, 8'h5A, 8'h5A, 1'b1}, // R3
    '{8'h00, 8'h00, 8'hFF, 8'h00, 8'hFF, 8'h0F, 8'hF0, 8'hF0, 1'b1}, // R4 rising
    '{8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hF0, 8'h0F, 1'b0}, // R4 falling
    '{8'h00, 8'hFF, 8'h00, 8'hF0, 8'h0F, 8'h00, 8'hFF, 8'h0F, 1'b1}, // R6
    '{8'hFF, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 8'h3C, 8'h3C, 1'b0}, // R5 high
    '{8'hFF, 8'h00, 8'h00, 8'h00, 8'h0F, 8'hFF, 8'hF0, 8'h0F, 1'b1}, // R5 low
    '{8'h0F, 8'h30, 8'hC5, 8'h00, 8'h40, 8'h00, 8'h65, 8'h6F, 1'b1}  // mixed
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(negedge clk); wr = 0;
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [7:0] exp);
    @(negedge clk); wr = 0; addr = a; #1;
    check(req, rdata, exp);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    rd_chk("R1", A_SENSE, 8'h00);
    rd_chk("R1", A_ANY, 8'h00);
    rd_chk("R1", A_POL, 8'h00);
    rd_chk("R1", A_MASK, 8'h00);
    rd_chk("R1", A_RAW, 8'h00);
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R2 register round trip
    wr_reg(A_POL, 8'hAB);
    rd_chk("R2", A_POL, 8'hAB);
    wr_reg(A_MASK, 8'h5C);
    rd_chk("R2", A_MASK, 8'h5C);

    // table walk
    for (int i = 0; i < 7; i++) begin
      @(negedge clk); dir = VEC[i].dir; pin = VEC[i].pa;
      wr_reg(A_SENSE, VEC[i].sense);
      wr_reg(A_ANY, VEC[i].any);
      wr_reg(A_POL, VEC[i].pol);
      wr_reg(A_MASK, VEC[i].mask);
      @(negedge clk); @(negedge clk);
      wr_reg(A_CLR, 8'hFF);
      pin = VEC[i].pb;
      rd_chk($sformatf("R3-R6 vec%0d raw", i), A_RAW, VEC[i].raw);
      check($sformatf("R9 vec%0d irq", i), {7'b0, irq}, {7'b0, VEC[i].irq});
      rd_chk($sformatf("R9 vec%0d masked", i), A_MSKD, VEC[i].raw & VEC[i].mask);
    end

    // R10 read-only and unmapped
    rd_chk("R10 pre", A_RAW, 8'h6F);
    wr_reg(A_RAW, 8'h00);
    wr_reg(A_MSKD, 8'h00);
    rd_chk("R10 raw write ignored", A_RAW, 8'h6F);
    rd_chk("R10 clear reads zero", A_CLR, 8'h00);
    rd_chk("R10 unmapped", 12'h000, 8'h00);

    // setup: all edge, any-change, inputs, pins low
    @(negedge clk); dir = 0; pin = 0;
    wr_reg(A_SENSE, 8'h00);
    wr_reg(A_ANY, 8'hFF);
    wr_reg(A_MASK, 8'hFF);
    wr_reg(A_CLR, 8'hFF);
    rd_chk("R7 cleared", A_RAW, 8'h00);

    // R11 steady pin, no re-trigger
    @(negedge clk); pin = 8'h01;
    @(negedge clk);
    wr_reg(A_CLR, 8'hFF);
    repeat (3) @(negedge clk);
    rd_chk("R11 steady", A_RAW, 8'h00);

    // R8 clear and event in the same clock
    @(negedge clk); pin = 8'h03; wr = 1; addr = A_CLR; wdata = 8'h02;
    @(negedge clk); wr = 0; addr = A_RAW; #1;
    check("R8 event wins", rdata, 8'h02);

    // R7 sticky, zero-write no effect, one-write clears
    wr_reg(A_ANY, 8'h00);
    wr_reg(A_POL, 8'hFF);
    @(negedge clk); pin = 8'h00;
    repeat (3) @(negedge clk);
    rd_chk("R7 sticky", A_RAW, 8'h02);
    wr_reg(A_CLR, 8'h00);
    rd_chk("R7 zero write", A_RAW, 8'h02);
    wr_reg(A_CLR, 8'h02);
    rd_chk("R7 cleared bit", A_RAW, 8'h00);
    check("R9 irq low", {7'b0, irq}, 8'h00);

    // R7 active level re-sets, inactive clears
    wr_reg(A_SENSE, 8'h01);
    @(negedge clk); pin = 8'h01;
    @(negedge clk);
    wr_reg(A_CLR, 8'h01);
    rd_chk("R7 level still active", A_RAW, 8'h01);
    @(negedge clk); pin = 8'h00;
    wr_reg(A_CLR, 8'h01);
    rd_chk("R7 level inactive", A_RAW, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule